// File: doc/BRIEF.md
# Single-Cycle 16-bit RISC Processor Core

This block is a small processor that finishes every instruction in one clock cycle. Each instruction is 16 bits wide and carries a 4-bit operation code in its top nibble. The core holds sixteen 16-bit general registers, and register 0 always reads as zero. The instruction store and the data store are separate word-addressed arrays inside the core. Instruction words are written through a load port, and the data store is reached only through load and store instructions.

The instruction fields are fixed. Bits 15:12 hold the operation code, bits 11:8 the destination `rd`, bits 7:4 the first source `rs` and bits 3:0 the second source `rt`. Immediate-form instructions use bits 7:0 as a signed byte. The long jump uses bits 11:0 as a signed 12-bit offset. All relative transfers are measured from the address of the transfer instruction itself.

A `halt` input freezes the core so that a host can load a program or inspect state. A debug read port returns the contents of any register one cycle after it is selected. Next-address selection is kept in a separate program-counter unit.

Top module: `tiny16_core`

## Requirements
- R1: While `rst` is sampled high at a clock edge, the program counter and all sixteen registers become 0. `pc_o` reads 0 on the cycle after such an edge.
- R2: The register operations write `rd` as follows: code 0 gives rs+rt, code 1 gives rs-rt, code 4 gives rs AND rt, code 5 gives rs OR rt, and code 6 gives NOT rs. Code 6 ignores `rt`. All results are modulo 2^16.
- R3: Code 8 adds the sign-extended bits 7:0 to `rd` and writes the sum back to `rd`, so an immediate of 0xFF decrements `rd` by one.
- R4: Code 9 writes bits 7:0 into bits 15:8 of `rd` and leaves bits 7:0 of `rd` unchanged.
- R5: Codes 2 (load) and 3 (store) address the data store at (rs+rt) modulo the store depth. A load writes the stored word into `rd`, and a store writes the contents of `rd` into the store.
- R6: Code 10 branches when `rd` equals zero and code 11 branches when `rd` is nonzero. A taken branch sets the next PC to PC plus the sign-extended bits 7:0. A branch that is not taken sets it to PC+1.
- R7: Code 15 sets the next PC to PC plus the sign-extended bits 11:0. Code 14 sets the next PC to the value of `rd`.
- R8: Code 13 writes PC+1 into register 1, whatever its `rd` field holds, and sets the next PC to PC plus the sign-extended bits 7:0.
- R9: Register 0 reads as zero through every port, and writes to it are discarded.
- R10: Codes 7 and 12 write no register and no memory, and advance the PC by one.
- R11: While `halt` is high, the PC holds its value and no register or data store write takes place.
- R12: The program 0x0100, 0x810A, 0x0200, 0x8201, 0x81FF, 0xB1FE at addresses 0 to 5 counts to ten: when its loop exits, r1 holds 0 and r2 holds 10.
- R13: `dbg_data` shows the register selected by `dbg_sel` at the previous clock edge. It reads 0 on the cycle after a reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt | input | 1 | Freezes execution while high |
| imem_we | input | 1 | Instruction store write enable |
| imem_waddr | input | IMEM_AW | Instruction store write address |
| imem_wdata | input | 16 | Instruction word to write |
| dbg_sel | input | 4 | Register index for the debug read |
| pc_o | output | 16 | Current program counter |
| dbg_data | output | 16 | Registered debug read of the selected register |

## Verification
The bound checker watches several rules on every cycle. It confirms that the PC and all writes freeze under halt, that register 0 reads as zero, that the unused codes do nothing, that a taken zero-branch lands at its relative target, and that the link write of the call goes to register 1 with PC+1. The bench scenarios are the only way to show that whole programs reach the right architectural state. This covers ALU results, the upper-byte load that keeps the low byte, store and load through wrapped addresses, forward and backward jumps, return through a register, and the counting loop. The bench shows this by comparing the PC with a behavioural model on every cycle and then sweeping all registers through the debug port.

// File: rtl/tiny16_pkg.sv
package tiny16_pkg;

  localparam int WORD_W = 16;
  localparam int REG_N  = 16;
  localparam int RIDX_W = $clog2(REG_N);

  typedef enum logic [3:0] {
    OP_ADD  = 4'h0, OP_SUB  = 4'h1, OP_LW   = 4'h2, OP_SW  = 4'h3,
    OP_AND  = 4'h4, OP_OR   = 4'h5, OP_NOT  = 4'h6, OP_RSV7 = 4'h7,
    OP_ADDI = 4'h8, OP_LDHI = 4'h9, OP_BZ   = 4'hA, OP_BNZ = 4'hB,
    OP_RSVC = 4'hC, OP_JAL  = 4'hD, OP_JR   = 4'hE, OP_J   = 4'hF
  } opcode_e;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_NOT, ALU_HIGH
  } alu_op_e;

  typedef enum logic [1:0] {
    WB_ALU, WB_MEM, WB_LINK
  } wb_sel_e;

  typedef enum logic [2:0] {
    NX_SEQ, NX_BZ, NX_BNZ, NX_REL8, NX_REL12, NX_REG
  } next_sel_e;

  typedef struct packed {
    logic      reg_we;
    logic      mem_we;
    logic      a_from_rd;
    logic      b_from_imm;
    logic      link_r1;
    alu_op_e   alu_op;
    wb_sel_e   wb_sel;
    next_sel_e nx_sel;
  } ctrl_t;

endpackage

// File: rtl/tiny16_decode.sv
module tiny16_decode
  import tiny16_pkg::*;
(
  input  logic [3:0] opcode,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl.reg_we     = 1'b0;
    ctrl.mem_we     = 1'b0;
    ctrl.a_from_rd  = 1'b0;
    ctrl.b_from_imm = 1'b0;
    ctrl.link_r1    = 1'b0;
    ctrl.alu_op     = ALU_ADD;
    ctrl.wb_sel     = WB_ALU;
    ctrl.nx_sel     = NX_SEQ;
    case (opcode_e'(opcode))
      OP_ADD:  ctrl.reg_we = 1'b1;
      OP_SUB:  begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_SUB; end
      OP_AND:  begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_AND; end
      OP_OR:   begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_OR;  end
      OP_NOT:  begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_NOT; end
      OP_LW:   begin ctrl.reg_we = 1'b1; ctrl.wb_sel = WB_MEM;  end
      OP_SW:   ctrl.mem_we = 1'b1;
      OP_ADDI: begin
        ctrl.reg_we     = 1'b1;
        ctrl.a_from_rd  = 1'b1;
        ctrl.b_from_imm = 1'b1;
      end
      OP_LDHI: begin
        ctrl.reg_we     = 1'b1;
        ctrl.a_from_rd  = 1'b1;
        ctrl.b_from_imm = 1'b1;
        ctrl.alu_op     = ALU_HIGH;
      end
      OP_BZ:   ctrl.nx_sel = NX_BZ;
      OP_BNZ:  ctrl.nx_sel = NX_BNZ;
      OP_JAL:  begin
        ctrl.reg_we  = 1'b1;
        ctrl.link_r1 = 1'b1;
        ctrl.wb_sel  = WB_LINK;
        ctrl.nx_sel  = NX_REL8;
      end
      OP_JR:   ctrl.nx_sel = NX_REG;
      OP_J:    ctrl.nx_sel = NX_REL12;
      default: ;
    endcase
  end

endmodule

// File: rtl/tiny16_alu.sv
module tiny16_alu
  import tiny16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y
);

  localparam int HALF = W / 2;

  always_comb begin
    case (op)
      ALU_SUB:  y = a - b;
      ALU_AND:  y = a & b;
      ALU_OR:   y = a | b;
      ALU_NOT:  y = ~a;
      ALU_HIGH: y = {b[HALF-1:0], a[HALF-1:0]};
      default:  y = a + b;
    endcase
  end

endmodule

// File: rtl/tiny16_regfile.sv
module tiny16_regfile #(
  parameter int W     = 16,
  parameter int N     = 16,
  parameter int NREAD = 4,
  localparam int AW   = $clog2(N)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [AW-1:0]              waddr,
  input  logic [W-1:0]               wdata,
  input  logic [NREAD-1:0][AW-1:0]   raddr,
  output logic [NREAD-1:0][W-1:0]    rdata
);

  logic [W-1:0] regs [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else if (we && (waddr != '0)) begin
      regs[waddr] <= wdata;
    end
  end

  for (genvar g = 0; g < NREAD; g++) begin : g_rd
    assign rdata[g] = (raddr[g] == '0) ? '0 : regs[raddr[g]];
  end

endmodule

// File: rtl/tiny16_pc.sv
module tiny16_pc
  import tiny16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         halt,
  input  next_sel_e    nx_sel,
  input  logic [W-1:0] rd_val,
  input  logic [7:0]   off8,
  input  logic [11:0]  off12,
  output logic [W-1:0] pc
);

  logic [W-1:0] seq_pc, rel8_pc, rel12_pc, next_pc;

  assign seq_pc   = pc + W'(1);
  assign rel8_pc  = pc + {{(W-8){off8[7]}}, off8};
  assign rel12_pc = pc + {{(W-12){off12[11]}}, off12};

  always_comb begin
    case (nx_sel)
      NX_BZ:    next_pc = (rd_val == '0) ? rel8_pc : seq_pc;
      NX_BNZ:   next_pc = (rd_val != '0) ? rel8_pc : seq_pc;
      NX_REL8:  next_pc = rel8_pc;
      NX_REL12: next_pc = rel12_pc;
      NX_REG:   next_pc = rd_val;
      default:  next_pc = seq_pc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       pc <= '0;
    else if (!halt) pc <= next_pc;
  end

endmodule

// File: rtl/tiny16_core.sv
module tiny16_core
  import tiny16_pkg::*;
#(
  parameter int IMEM_AW = 8,
  parameter int DMEM_AW = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               halt,
  input  logic               imem_we,
  input  logic [IMEM_AW-1:0] imem_waddr,
  input  logic [15:0]        imem_wdata,
  input  logic [3:0]         dbg_sel,
  output logic [15:0]        pc_o,
  output logic [15:0]        dbg_data
);

  localparam int IMEM_D = 1 << IMEM_AW;
  localparam int DMEM_D = 1 << DMEM_AW;
  localparam int NREAD  = 4;

  logic [WORD_W-1:0] imem [IMEM_D];
  logic [WORD_W-1:0] dmem [DMEM_D];

  logic [WORD_W-1:0] instr;
  logic [3:0]        op;
  logic [RIDX_W-1:0] f_rd, f_rs, f_rt;
  logic [7:0]        imm8;
  logic [WORD_W-1:0] imm8_sx;
  ctrl_t             ctrl;

  logic [NREAD-1:0][RIDX_W-1:0] rf_raddr;
  logic [NREAD-1:0][WORD_W-1:0] rf_rdata;
  logic [WORD_W-1:0] rs_val, rt_val, rd_val;

  logic [WORD_W-1:0] alu_a, alu_b, alu_y;
  logic [WORD_W-1:0] mem_rdata;
  logic [DMEM_AW-1:0] dm_addr;

  logic              rf_we, dm_we;
  logic [RIDX_W-1:0] rf_waddr;
  logic [WORD_W-1:0] rf_wdata;

  // instruction store: synchronous write port, fetch read at the PC
  always_ff @(posedge clk) begin
    if (imem_we) imem[imem_waddr] <= imem_wdata;
  end

  assign instr   = imem[pc_o[IMEM_AW-1:0]];
  assign op      = instr[15:12];
  assign f_rd    = instr[11:8];
  assign f_rs    = instr[7:4];
  assign f_rt    = instr[3:0];
  assign imm8    = instr[7:0];
  assign imm8_sx = {{(WORD_W-8){imm8[7]}}, imm8};

  tiny16_decode u_dec (
    .opcode (op),
    .ctrl   (ctrl)
  );

  assign rf_raddr[0] = f_rs;
  assign rf_raddr[1] = f_rt;
  assign rf_raddr[2] = f_rd;
  assign rf_raddr[3] = dbg_sel;
  assign rs_val = rf_rdata[0];
  assign rt_val = rf_rdata[1];
  assign rd_val = rf_rdata[2];

  tiny16_regfile #(
    .W     (WORD_W),
    .N     (REG_N),
    .NREAD (NREAD)
  ) u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (rf_we),
    .waddr (rf_waddr),
    .wdata (rf_wdata),
    .raddr (rf_raddr),
    .rdata (rf_rdata)
  );

  assign alu_a = ctrl.a_from_rd  ? rd_val  : rs_val;
  assign alu_b = ctrl.b_from_imm ? imm8_sx : rt_val;

  tiny16_alu #(.W(WORD_W)) u_alu (
    .a  (alu_a),
    .b  (alu_b),
    .op (ctrl.alu_op),
    .y  (alu_y)
  );

  // data store: address wraps to the store depth
  assign dm_addr   = alu_y[DMEM_AW-1:0];
  assign dm_we     = ctrl.mem_we & ~halt & ~rst;
  assign mem_rdata = dmem[dm_addr];

  always_ff @(posedge clk) begin
    if (dm_we) dmem[dm_addr] <= rd_val;
  end

  assign rf_we    = ctrl.reg_we & ~halt;
  assign rf_waddr = ctrl.link_r1 ? RIDX_W'(1) : f_rd;

  always_comb begin
    case (ctrl.wb_sel)
      WB_MEM:  rf_wdata = mem_rdata;
      WB_LINK: rf_wdata = pc_o + WORD_W'(1);
      default: rf_wdata = alu_y;
    endcase
  end

  tiny16_pc #(.W(WORD_W)) u_pc (
    .clk    (clk),
    .rst    (rst),
    .halt   (halt),
    .nx_sel (ctrl.nx_sel),
    .rd_val (rd_val),
    .off8   (imm8),
    .off12  (instr[11:0]),
    .pc     (pc_o)
  );

  always_ff @(posedge clk) begin
    if (rst) dbg_data <= '0;
    else     dbg_data <= rf_rdata[3];
  end

endmodule

// File: rtl/tiny16_core_chk.sv
module tiny16_core_chk (
  input logic        clk,
  input logic        rst,
  input logic        halt,
  input logic [15:0] pc_o,
  input logic [3:0]  dbg_sel,
  input logic [15:0] dbg_data,
  input logic [3:0]  op,
  input logic [7:0]  imm8,
  input logic [15:0] rd_val,
  input logic        rf_we,
  input logic [3:0]  rf_waddr,
  input logic [15:0] rf_wdata,
  input logic        dm_we
);

  logic rst_q = 1'b0;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    // R1
    if (rst_q) begin
      pc_reset_chk: assert (pc_o == 16'd0) else $error("pc not cleared by reset");
    end
  end

  // R11
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    halt |=> $stable(pc_o));

  // R11
  halt_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    halt |-> (!rf_we && !dm_we));

  // R9
  zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
    (dbg_sel == 4'd0) |=> (dbg_data == 16'd0));

  // R10
  unused_op_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    (!halt && (op == 4'h7 || op == 4'hC)) |-> (!rf_we && !dm_we));

  // R10
  unused_op_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!halt && (op == 4'h7 || op == 4'hC)) |=> (pc_o == $past(pc_o) + 16'd1));

  // R6
  bz_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (!halt && op == 4'hA && rd_val == 16'd0)
      |=> (pc_o == $past(pc_o) + {{8{$past(imm8[7])}}, $past(imm8)}));

  // R8
  jal_link_chk: assert property (@(posedge clk) disable iff (rst)
    (!halt && op == 4'hD) |-> (rf_we && rf_waddr == 4'd1 && rf_wdata == pc_o + 16'd1));

endmodule

bind tiny16_core tiny16_core_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .halt     (halt),
  .pc_o     (pc_o),
  .dbg_sel  (dbg_sel),
  .dbg_data (dbg_data),
  .op       (op),
  .imm8     (imm8),
  .rd_val   (rd_val),
  .rf_we    (rf_we),
  .rf_waddr (rf_waddr),
  .rf_wdata (rf_wdata),
  .dm_we    (dm_we)
);

// File: tb/tiny16_core_test.sv
`timescale 1ns/1ps
module tiny16_core_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        halt = 1'b1;
  logic        imem_we = 1'b0;
  logic [7:0]  imem_waddr = '0;
  logic [15:0] imem_wdata = '0;
  logic [3:0]  dbg_sel = '0;
  logic [15:0] pc_o;
  logic [15:0] dbg_data;

  int n_checks = 0;
  int n_fail   = 0;
  string cur_tag = "R1";

  // behavioural reference state
  logic [15:0] m_regs [16];
  logic [15:0] m_dmem [256];
  logic [15:0] m_imem [256];
  logic [15:0] m_pc;

  always #4 clk = ~clk;

  tiny16_core uut (
    .clk        (clk),
    .rst        (rst),
    .halt       (halt),
    .imem_we    (imem_we),
    .imem_waddr (imem_waddr),
    .imem_wdata (imem_wdata),
    .dbg_sel    (dbg_sel),
    .pc_o       (pc_o),
    .dbg_data   (dbg_data)
  );

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] sx8(input logic [7:0] v);
    return {{8{v[7]}}, v};
  endfunction

  task automatic model_step();
    logic [15:0] w, rdv, rsv, rtv, npc, addr;
    int op, rd, rs, rt;
    w  = m_imem[m_pc[7:0]];
    op = int'(w[15:12]);
    rd = int'(w[11:8]);
    rs = int'(w[7:4]);
    rt = int'(w[3:0]);
    rdv = m_regs[rd];
    rsv = m_regs[rs];
    rtv = m_regs[rt];
    npc = m_pc + 16'd1;
    addr = rsv + rtv;
    case (op)
      0:  m_regs[rd] = rsv + rtv;
      1:  m_regs[rd] = rsv - rtv;
      2:  m_regs[rd] = m_dmem[addr[7:0]];
      3:  m_dmem[addr[7:0]] = rdv;
      4:  m_regs[rd] = rsv & rtv;
      5:  m_regs[rd] = rsv | rtv;
      6:  m_regs[rd] = ~rsv;
      8:  m_regs[rd] = rdv + sx8(w[7:0]);
      9:  m_regs[rd] = {w[7:0], rdv[7:0]};
      10: if (rdv == 16'd0) npc = m_pc + sx8(w[7:0]);
      11: if (rdv != 16'd0) npc = m_pc + sx8(w[7:0]);
      13: begin m_regs[1] = m_pc + 16'd1; npc = m_pc + sx8(w[7:0]); end
      14: npc = rdv;
      15: npc = m_pc + {{4{w[11]}}, w[11:0]};
      default: ;
    endcase
    m_regs[0] = 16'd0;
    m_pc = npc;
  endtask

  // one clock: advance the model at the edge, compare PC between edges
  task automatic tick();
    @(posedge clk);
    if (rst) begin
      m_pc = 16'd0;
      for (int i = 0; i < 16; i++) m_regs[i] = 16'd0;
    end else if (!halt) begin
      model_step();
    end
    @(negedge clk);
    check({cur_tag, " pc trace"}, pc_o, m_pc);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    halt = 1'b1;
    tick();
    tick();
    rst = 1'b0;
  endtask

  task automatic load_prog(input logic [15:0] words[$]);
    halt = 1'b1;
    foreach (words[i]) begin
      imem_we = 1'b1;
      imem_waddr = 8'(i);
      imem_wdata = words[i];
      m_imem[i] = words[i];
      tick();
    end
    imem_we = 1'b0;
  endtask

  task automatic run(input int n);
    halt = 1'b0;
    repeat (n) tick();
    halt = 1'b1;
    tick();
  endtask

  task automatic read_reg(input int r, output logic [15:0] v);
    dbg_sel = 4'(r);
    tick();
    v = dbg_data;
  endtask

  task automatic sweep_regs(input string tag);
    logic [15:0] v;
    for (int r = 0; r < 16; r++) begin
      read_reg(r, v);
      check({tag, " reg sweep"}, v, m_regs[r]);
    end
  endtask

  task automatic expect_reg(input string tag, input int r, input logic [15:0] exp);
    logic [15:0] v;
    read_reg(r, v);
    check(tag, v, exp);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    logic [15:0] pc_hold;
    logic [15:0] prog[$];
    for (int i = 0; i < 256; i++) begin m_imem[i] = 16'd0; m_dmem[i] = 16'd0; end
    m_pc = 16'd0;
    for (int i = 0; i < 16; i++) m_regs[i] = 16'd0;
    @(negedge clk);

    // R1, R13: state after reset
    cur_tag = "R1";
    do_reset();
    check("R1 pc after reset", pc_o, 16'd0);
    check("R13 debug after reset", dbg_data, 16'd0);
    sweep_regs("R1");

    // R12: counting loop, with a halt in the middle (R11)
    cur_tag = "R12";
    prog = '{16'h0100, 16'h810A, 16'h0200, 16'h8201, 16'h81FF, 16'hB1FE, 16'hF000};
    load_prog(prog);
    halt = 1'b0;
    repeat (10) tick();
    halt = 1'b1;
    cur_tag = "R11";
    pc_hold = pc_o;
    repeat (6) tick();
    check("R11 pc held under halt", pc_o, pc_hold);
    cur_tag = "R12";
    run(40);
    expect_reg("R12 r1 at loop exit", 1, 16'd0);
    expect_reg("R12 r2 at loop exit", 2, 16'd10);
    check("R7 spin on zero jump", pc_o, 16'd6);
    sweep_regs("R12");

    // R1: reset clears nonzero registers
    cur_tag = "R1";
    do_reset();
    expect_reg("R1 r2 cleared", 2, 16'd0);
    sweep_regs("R1");

    // R2, R3, R4, R9, R10: ALU, immediates, zero register, unused codes
    cur_tag = "R2";
    prog = '{16'h8305, 16'h9412, 16'h84FF, 16'h94AB, 16'h0534, 16'h1634,
             16'h4743, 16'h5843, 16'h6947, 16'h0034, 16'h8077, 16'h7A34,
             16'hCB12, 16'hF000};
    load_prog(prog);
    run(20);
    expect_reg("R3 addi", 3, 16'h0005);
    expect_reg("R4 ldhi keeps low byte", 4, 16'hABFF);
    expect_reg("R2 add", 5, 16'hAC04);
    expect_reg("R2 sub", 6, 16'h5406);
    expect_reg("R2 and", 7, 16'h0005);
    expect_reg("R2 or", 8, 16'hABFF);
    expect_reg("R2 not ignores rt", 9, 16'h5400);
    expect_reg("R9 r0 write discarded", 0, 16'h0000);
    expect_reg("R10 code 7 no write", 10, 16'h0000);
    expect_reg("R10 code 12 no write", 11, 16'h0000);
    check("R10 spin reached", pc_o, 16'd13);
    sweep_regs("R2");

    // R5: store and load, including an address that wraps
    cur_tag = "R5";
    do_reset();
    prog = '{16'h8A03, 16'h8B04, 16'h8C7E, 16'h3CAB, 16'h2DBA, 16'h8EFF,
             16'h3E0E, 16'h2F0E, 16'hF000};
    load_prog(prog);
    run(12);
    expect_reg("R5 load after store", 13, 16'h007E);
    expect_reg("R5 wrapped address", 15, 16'hFFFF);
    sweep_regs("R5");

    // R6, R7, R8: branches, jumps, call and return
    cur_tag = "R6";
    do_reset();
    prog = '{16'hA102, 16'h8101, 16'h8203, 16'hA202, 16'hB202, 16'h8301,
             16'hD503, 16'h8401, 16'hF003, 16'h8602, 16'hE100, 16'hF002,
             16'hF000, 16'h8701, 16'hFFFE};
    load_prog(prog);
    run(20);
    expect_reg("R8 link into r1", 1, 16'd7);
    expect_reg("R6 taken bz skipped", 3, 16'd0);
    expect_reg("R6 fallthrough", 2, 16'd3);
    expect_reg("R7 jr return path", 4, 16'd1);
    expect_reg("R8 call target ran", 6, 16'd2);
    expect_reg("R7 forward j", 7, 16'd1);
    expect_reg("R8 rd field untouched", 5, 16'd0);
    check("R7 backward j", pc_o, 16'd12);
    sweep_regs("R6");

    report();
    $finish;
  end

endmodule